// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit logical address to a physical address through a small, fixed set of large-block translation entries. Each entry holds five things: a compare value, a high-order mask, a physical base, two protection bits and two privilege-enable bits. The block keeps two independent sets of entries, one for instruction fetches and one for data accesses. A request input picks which set is searched.

A lookup request carries the address, the privilege level (user or supervisor), a write flag and the set select. The request is captured in a register. The lookup itself is combinational and runs on that captured request. The result is registered with a valid strobe, so it appears two clock edges after the request is presented.

The result gives a hit flag, the protection bits, the merged physical address and a fault flag. When the fault flag is set, it also gives a status word and the faulting address. Entries are written through a simple load port, one entry per cycle.

Top module: `blkmap_xlate`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0. Every entry has its privilege-enable bits cleared, so no lookup hits.
- R2: An entry matches when both of these hold:
  - (entry enable AND {~req_user, req_user}) is non-zero. Enable bit 1 permits supervisor access and bit 0 permits user access.
  - (address AND entry mask) equals the entry compare value.
- R3: When several entries of the searched set match, the one with the lowest index is used.
- R4: On a hit, `rsp_paddr` = entry base OR (address AND NOT entry mask), and `rsp_prot` returns the entry's protection bits.
- R5: `req_data`=1 searches the data set and 0 searches the instruction set. `ld_bank` uses the same encoding for writes, and a write to one set never changes lookups in the other.
- R6: A data-set hit faults when the protection bits are 00, or when protection bit 0 is set and the access is a write. An instruction-set lookup never faults.
- R7: On a fault, `rsp_status` = 0x08000000, with bit 25 also set for a write, and `rsp_fault_addr` = the request address. Without a fault, both are 0.
- R8: On a miss, `rsp_hit`, `rsp_fault`, `rsp_prot` and `rsp_paddr` are all 0.
- R9: A request presented at a clock edge gives exactly one `rsp_valid` pulse at the following edge. No response appears without a request.
- R10: An entry written by the load port at a clock edge is used by a lookup whose request is captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one entry |
| ld_bank | input | 1 | Target set: 1 data, 0 instruction |
| ld_idx | input | 2 | Entry index |
| ld_cmp | input | 32 | Compare value |
| ld_mask | input | 32 | High-order mask |
| ld_base | input | 32 | Physical base |
| ld_prot | input | 2 | Protection bits |
| ld_en_priv | input | 2 | Privilege enables: bit 1 supervisor, bit 0 user |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical address |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| req_write | input | 1 | 1 = write access |
| req_data | input | 1 | 1 = search data set, 0 = instruction set |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | An entry matched |
| rsp_prot | output | 2 | Protection bits of the matching entry |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Protection violation |
| rsp_status | output | 32 | Fault status word |
| rsp_fault_addr | output | 32 | Faulting logical address |

## Verification
The bench sets up overlapping entries so that more than one entry matches. A design with the priority reversed would return the higher entry's base.

It sets supervisor-only and user-only enables and crosses them with both privilege levels. An inverted qualifier would hit where it must miss.

It crosses every protection code with reads and writes in both sets. A wrong fault rule would raise faults on instruction fetches or on read-only reads, or would set bit 25 on reads.

Finally, it issues a lookup in the same cycle as the load that creates the matching entry. It does this alongside randomly generated entries and addresses that are checked against a reference model kept in the bench.

// File: rtl/blkmap_pkg.sv
// Shared types and constants for the block translation matcher.
package blkmap_pkg;
    parameter int unsigned AW = 32;

    // One translation entry.
    typedef struct packed {
        logic [AW-1:0] cmp;
        logic [AW-1:0] mask;
        logic [AW-1:0] base;
        logic [1:0]    prot;
        logic [1:0]    priv;   // bit 1 supervisor, bit 0 user
    } blk_ent_t;

    localparam logic [31:0] FSTAT_BASE = 32'h0800_0000;
    localparam int unsigned FSTAT_WR_BIT = 25;
endpackage

// File: rtl/blkmap_bank.sv
// One set of translation entries with a single write port.
// Assumes: one entry is written per cycle; reset clears the privilege
// enables so that no entry can match until it is loaded.
module blkmap_bank
    import blkmap_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDXW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDXW-1:0]        wr_idx,
    input  blk_ent_t               wr_ent,
    output blk_ent_t [N_ENT-1:0]   ents_o
);
    blk_ent_t [N_ENT-1:0] ents_q;

    // Entry storage: clear on reset, write the addressed entry on wr_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else if (wr_en) begin
            ents_q[wr_idx] <= wr_ent;
        end
    end

    assign ents_o = ents_q;

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ents_o[$past(wr_idx)] == $past(wr_ent));
endmodule

// File: rtl/blkmap_match.sv
// Priority-ordered masked match over one set of entries.
// Assumes: qual is one-hot ({supervisor, user}); purely combinational.
module blkmap_match
    import blkmap_pkg::*;
#(
    parameter int unsigned N_ENT = 4
) (
    input  blk_ent_t [N_ENT-1:0] ents,
    input  logic [AW-1:0]        addr,
    input  logic [1:0]           qual,
    output logic                 hit,
    output logic [1:0]           prot,
    output logic [AW-1:0]        paddr
);
    logic [N_ENT-1:0] cand;

    // Per-entry match: privilege enable and masked compare.
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cand
        assign cand[gi] = (|(ents[gi].priv & qual)) &&
                          ((addr & ents[gi].mask) == ents[gi].cmp);
    end

    // Pick the lowest-indexed candidate and merge base with offset.
    always_comb begin
        hit   = 1'b0;
        prot  = '0;
        paddr = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit   = 1'b1;
                prot  = ents[i].prot;
                paddr = ents[i].base | (addr & ~ents[i].mask);
            end
        end
    end
endmodule

// File: rtl/blkmap_xlate.sv
// Block translation matcher top: request register, two entry sets,
// combinational lookup, registered result with fault status.
// Assumes: one lookup per request pulse; result valid one edge after capture.
module blkmap_xlate
    import blkmap_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDXW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int unsigned N_SET = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic            ld_bank,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [AW-1:0]   ld_cmp,
    input  logic [AW-1:0]   ld_mask,
    input  logic [AW-1:0]   ld_base,
    input  logic [1:0]      ld_prot,
    input  logic [1:0]      ld_en_priv,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_user,
    input  logic            req_write,
    input  logic            req_data,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [1:0]      rsp_prot,
    output logic [AW-1:0]   rsp_paddr,
    output logic            rsp_fault,
    output logic [31:0]     rsp_status,
    output logic [AW-1:0]   rsp_fault_addr
);
    logic          q_valid, q_user, q_write, q_data;
    logic [AW-1:0] q_addr;
    blk_ent_t      ld_ent;
    blk_ent_t [N_ENT-1:0] set_ents [N_SET];
    logic          m_hit, fault_c;
    logic [1:0]    m_prot;
    logic [AW-1:0] m_paddr;

    assign ld_ent = '{cmp: ld_cmp, mask: ld_mask, base: ld_base,
                      prot: ld_prot, priv: ld_en_priv};

    // Request capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_addr  <= '0;
            q_user  <= 1'b0;
            q_write <= 1'b0;
            q_data  <= 1'b0;
        end else begin
            q_valid <= req_valid;
            if (req_valid) begin
                q_addr  <= req_addr;
                q_user  <= req_user;
                q_write <= req_write;
                q_data  <= req_data;
            end
        end
    end

    // Entry sets: index 0 instruction, index 1 data.
    for (genvar gs = 0; gs < N_SET; gs++) begin : g_set
        blkmap_bank #(.N_ENT(N_ENT)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ld_en && (ld_bank == gs[0])),
            .wr_idx (ld_idx),
            .wr_ent (ld_ent),
            .ents_o (set_ents[gs])
        );
    end

    blkmap_match #(.N_ENT(N_ENT)) u_match (
        .ents  (q_data ? set_ents[1] : set_ents[0]),
        .addr  (q_addr),
        .qual  ({~q_user, q_user}),
        .hit   (m_hit),
        .prot  (m_prot),
        .paddr (m_paddr)
    );

    // Protection check: data set only.
    assign fault_c = q_data && m_hit &&
                     ((m_prot == 2'b00) || (m_prot[0] && q_write));

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_prot       <= '0;
            rsp_paddr      <= '0;
            rsp_fault      <= 1'b0;
            rsp_status     <= '0;
            rsp_fault_addr <= '0;
        end else begin
            rsp_valid      <= q_valid;
            rsp_hit        <= m_hit;
            rsp_prot       <= m_prot;
            rsp_paddr      <= m_paddr;
            rsp_fault      <= fault_c;
            rsp_status     <= fault_c ? (FSTAT_BASE | (32'(q_write) << FSTAT_WR_BIT)) : '0;
            rsp_fault_addr <= fault_c ? q_addr : '0;
        end
    end

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !rsp_valid);
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (!rsp_fault && rsp_paddr == '0 && rsp_prot == '0));
    a_r6_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    a_r6_ifetch_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !q_data |=> !rsp_fault);
    a_r7_status_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_status[27] && $countones(rsp_status) <= 2));
    a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> (rsp_status == '0 && rsp_fault_addr == '0));
endmodule

// File: tb/sim_blkmap_xlate.sv
module sim_blkmap_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 0, ld_bank = 0;
    logic [1:0]  ld_idx = 0, ld_prot = 0, ld_en_priv = 0;
    logic [31:0] ld_cmp = 0, ld_mask = 0, ld_base = 0;
    logic        req_valid = 0, req_user = 0, req_write = 0, req_data = 0;
    logic [31:0] req_addr = 0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [1:0]  rsp_prot;
    logic [31:0] rsp_paddr, rsp_status, rsp_fault_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model of both sets.
    logic [31:0] m_cmp [2][4];
    logic [31:0] m_mask[2][4];
    logic [31:0] m_base[2][4];
    logic [1:0]  m_prot[2][4];
    logic [1:0]  m_priv[2][4];

    always #5 clk = ~clk;

    blkmap_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_cmp(ld_cmp),
        .ld_mask(ld_mask), .ld_base(ld_base), .ld_prot(ld_prot), .ld_en_priv(ld_en_priv),
        .req_valid(req_valid), .req_addr(req_addr), .req_user(req_user),
        .req_write(req_write), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_prot(rsp_prot),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rsp_fault_addr(rsp_fault_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Drive load signals for the next edge (caller steps the clock).
    task automatic set_load(input bit bank, input int idx, input logic [31:0] cmp,
                            input logic [31:0] mask, input logic [31:0] base,
                            input logic [1:0] prot, input logic [1:0] priv);
        ld_en = 1; ld_bank = bank; ld_idx = idx[1:0];
        ld_cmp = cmp; ld_mask = mask; ld_base = base; ld_prot = prot; ld_en_priv = priv;
        m_cmp[bank][idx] = cmp; m_mask[bank][idx] = mask; m_base[bank][idx] = base;
        m_prot[bank][idx] = prot; m_priv[bank][idx] = priv;
    endtask

    task automatic load(input bit bank, input int idx, input logic [31:0] cmp,
                        input logic [31:0] mask, input logic [31:0] base,
                        input logic [1:0] prot, input logic [1:0] priv);
        set_load(bank, idx, cmp, mask, base, prot, priv);
        @(negedge clk);
        ld_en = 0;
    endtask

    // Expected result from the requirements (R2..R8).
    task automatic model(input logic [31:0] a, input bit user, input bit wr, input bit dset,
                         output bit hit, output logic [1:0] prot, output logic [31:0] pa,
                         output bit flt, output logic [31:0] st, output logic [31:0] fa);
        logic [1:0] q;
        q = {~user, user};
        hit = 0; prot = 0; pa = 0;
        for (int i = 0; i < 4; i++) begin
            if (!hit && ((m_priv[dset][i] & q) != 0) && ((a & m_mask[dset][i]) == m_cmp[dset][i])) begin
                hit = 1; prot = m_prot[dset][i];
                pa = m_base[dset][i] | (a & ~m_mask[dset][i]);
            end
        end
        flt = dset && hit && (prot == 0 || (prot[0] && wr));
        st = flt ? (32'h0800_0000 | (wr ? 32'h0200_0000 : 0)) : 0;
        fa = flt ? a : 0;
    endtask

    task automatic set_req(input logic [31:0] a, input bit user, input bit wr, input bit dset);
        req_valid = 1; req_addr = a; req_user = user; req_write = wr; req_data = dset;
    endtask

    // Request already driven; step two edges and compare.
    task automatic finish_lookup(input string tag);
        bit hit, flt; logic [1:0] prot; logic [31:0] pa, st, fa;
        model(req_addr, req_user, req_write, req_data, hit, prot, pa, flt, st, fa);
        @(negedge clk);
        ld_en = 0;
        req_valid = 0;
        chk(rsp_valid == 0, {tag, " R9 early"}, rsp_valid, 0);
        @(negedge clk);
        chk(rsp_valid == 1, {tag, " R9 valid"}, rsp_valid, 1);
        chk(rsp_hit == hit, {tag, " R2/R3 hit"}, rsp_hit, hit);
        chk(rsp_prot == prot, {tag, " R4 prot"}, rsp_prot, prot);
        chk(rsp_paddr == pa, {tag, " R4/R8 paddr"}, rsp_paddr, pa);
        chk(rsp_fault == flt, {tag, " R6 fault"}, rsp_fault, flt);
        chk(rsp_status == st, {tag, " R7 status"}, rsp_status, st);
        chk(rsp_fault_addr == fa, {tag, " R7 addr"}, rsp_fault_addr, fa);
        @(negedge clk);
        chk(rsp_valid == 0, {tag, " R9 single"}, rsp_valid, 0);
    endtask

    task automatic lookup(input logic [31:0] a, input bit user, input bit wr, input bit dset, input string tag);
        set_req(a, user, wr, dset);
        finish_lookup(tag);
    endtask

    function automatic logic [31:0] rmask(input int k);
        return ~((32'h0002_0000 << k) - 1);
    endfunction

    initial begin
        void'($urandom(32'h1234_5678));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 4; i++) begin
                m_cmp[b][i] = 0; m_mask[b][i] = 0; m_base[b][i] = 0;
                m_prot[b][i] = 0; m_priv[b][i] = 0;
            end
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0, "R1 valid", rsp_valid, 0);
        chk(rsp_hit == 0, "R1 hit", rsp_hit, 0);
        chk(rsp_fault == 0, "R1 fault", rsp_fault, 0);
        rst_n = 1;
        @(negedge clk);
        lookup(32'h0000_0000, 0, 0, 1, "R1 empty data");
        lookup(32'h0000_0000, 1, 0, 0, "R1 empty instr");

        // R3: overlapping entries 1 and 2 in data set; entry 1 wins.
        load(1, 2, 32'h1000_0000, 32'hF000_0000, 32'hA000_0000, 2'b10, 2'b11);
        load(1, 1, 32'h1000_0000, 32'hFFF0_0000, 32'hB000_0000, 2'b10, 2'b11);
        lookup(32'h1001_2345, 0, 1, 1, "R3 lower index wins");
        lookup(32'h1801_2345, 0, 1, 1, "R3 only upper");
        // R2: privilege enables.
        load(1, 0, 32'h2000_0000, 32'hFFFE_0000, 32'h3000_0000, 2'b10, 2'b10);
        lookup(32'h2001_0004, 1, 0, 1, "R2 user blocked");
        lookup(32'h2001_0004, 0, 0, 1, "R2 supervisor ok");
        load(1, 3, 32'h4000_0000, 32'hFFFE_0000, 32'h5000_0000, 2'b10, 2'b01);
        lookup(32'h4000_8000, 0, 0, 1, "R2 supervisor blocked");
        lookup(32'h4000_8000, 1, 0, 1, "R2 user ok");
        // R6/R7: protection codes in data set, same entries in instruction set.
        for (int p = 0; p < 4; p++) begin
            load(1, 0, 32'h6000_0000, 32'hFFFE_0000, 32'h7000_0000, p[1:0], 2'b11);
            load(0, 0, 32'h6000_0000, 32'hFFFE_0000, 32'h7100_0000, p[1:0], 2'b11);
            lookup(32'h6001_FFFC, 0, 0, 1, "R6 data read");
            lookup(32'h6001_FFFC, 1, 1, 1, "R6 data write");
            lookup(32'h6001_FFFC, 0, 1, 0, "R6 instr no fault");
        end
        // R5: instruction set write leaves data set alone.
        load(0, 1, 32'h8000_0000, 32'hF000_0000, 32'h9000_0000, 2'b10, 2'b11);
        lookup(32'h8123_4567, 0, 0, 1, "R5 data set untouched");
        lookup(32'h8123_4567, 0, 0, 0, "R5 instr set hit");
        // R10: load and lookup captured at the same edge.
        set_load(1, 2, 32'hC000_0000, 32'hFF00_0000, 32'hD000_0000, 2'b11, 2'b11);
        set_req(32'hC0AB_CDEF, 0, 1, 1);
        finish_lookup("R10 same-cycle load");
        // R8: plain miss.
        lookup(32'hEEEE_0000, 0, 0, 1, "R8 miss");

        // Random phase.
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                int k; logic [31:0] mk;
                k = $urandom_range(0, 7);
                mk = rmask(k);
                load($urandom_range(0, 1), $urandom_range(0, 3), $urandom() & mk, mk,
                     $urandom() & mk, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            end
            begin
                bit ds; int ix; logic [31:0] a;
                ds = 1'($urandom_range(0, 1));
                ix = $urandom_range(0, 3);
                a = $urandom();
                if ($urandom_range(0, 3) != 0) a = m_cmp[ds][ix] | (a & ~m_mask[ds][ix]);
                lookup(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ds, "R2-random");
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule